// File: doc/BRIEF.md
# UART Auto Flow-Control Controller

This block is the enable and flow-control core of a small auxiliary UART. It holds an 8-bit control register and a one-bit modem register. From these it works out three things: whether the receiver accepts characters, whether the transmitter may start a new character, and the level of the RTS pin. The serial shifters, the baud generator and the FIFOs are outside the block. The block sees the receive FIFO only through its occupancy count and a per-character arrival strobe.

Automatic RTS compares the free space in the 8-entry receive FIFO against a threshold chosen by a 2-bit field. RTS is released once free space falls to that threshold or below. Automatic CTS samples the CTS pin through a synchronizer and stops new characters from starting while the pin is inactive. Each of the two signals has its own polarity-inversion bit. When automatic RTS is off, the modem register bit drives the pin directly.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset the control register holds 0x03, so the receiver and the transmitter are enabled and every flow-control feature is off. The modem RTS bit resets to 0, so `rts_pin` is 0.
- R2: Control bit 0 drives `rx_enable`. While it is 0, `rx_char_valid` is discarded: `rx_push` stays 0.
- R3: Control bit 1 enables the transmitter. While it is 0, `tx_permit` is 0.
- R4: When control bit 2 is 1, the RTS level before inversion is 1 while the free receive slots (8 minus `rx_level`) exceed the selected threshold. It is 0 once the free slots are equal to or below the threshold.
- R5: Control bits 5:4 select the threshold in free slots: 00 selects 3, 01 selects 2, 10 selects 1 and 11 selects 4.
- R6: Control bit 6 inverts the automatic RTS level on `rts_pin`.
- R7: When control bit 3 is 1, `tx_permit` is 1 only while the synchronized CTS is active. `tx_permit` is always 0 while `tx_idle` is 0, so a character already in flight is not interrupted and a new one starts only at idle.
- R8: With control bit 7 at 0, CTS is active when the pin is 1. Control bit 7 makes a pin level of 0 active.
- R9: CTS passes through two flops. A pin change made between edges reaches `tx_permit` after the second following rising edge.
- R10: A write with `wr_sel`=1 stores `wr_data[0]` as the modem RTS bit. When automatic RTS is off, `rts_pin` equals that bit, and the RTS inversion bit has no effect on it.
- R11: A write with `wr_sel`=0 replaces the control register at the clock edge where `wr_en` is sampled. All outputs reflect the new value, including a new threshold against the current `rx_level`, in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the modem register |
| wr_data | input | 8 | Write data |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| rx_char_valid | input | 1 | Received character ready to store |
| cts_pin | input | 1 | Asynchronous CTS pin |
| tx_idle | input | 1 | Transmit shifter holds no character |
| rts_pin | output | 1 | RTS pin level |
| rx_enable | output | 1 | Receiver enable |
| rx_push | output | 1 | Store strobe to the receive FIFO |
| tx_permit | output | 1 | New transmit character may start |

## Verification
The assertions check on every cycle that nothing is pushed while the receiver is off and that nothing starts while the shifter is busy. They also check that a full FIFO always releases automatic RTS, and that control and modem writes appear on the outputs one edge later. The bench's scenarios are needed for the rest. They sweep every threshold code across every fill level and compare each polarity combination. They also measure the two-edge CTS latency and confirm that the inversion bit leaves manual RTS untouched. A behavioural model compares all four outputs on every clock.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    // Control register layout; bit positions are software visible.
    typedef struct packed {
        logic       cts_inv;   // [7]
        logic       rts_inv;   // [6]
        logic [1:0] thr_sel;   // [5:4]
        logic       auto_cts;  // [3]
        logic       auto_rts;  // [2]
        logic       tx_en;     // [1]
        logic       rx_en;     // [0]
    } fc_ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h03;

    typedef enum logic {
        WSEL_CTRL  = 1'b0,
        WSEL_MODEM = 1'b1
    } fc_wsel_e;

    // Free-slot threshold selected by the 2-bit field (non-monotonic code).
    function automatic logic [2:0] thr_slots(input logic [1:0] sel);
        case (sel)
            2'b00:   thr_slots = 3'd3;
            2'b01:   thr_slots = 3'd2;
            2'b10:   thr_slots = 3'd1;
            default: thr_slots = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/uart_fc_regs.sv
module uart_fc_regs
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output fc_ctrl_t   ctrl_q,
    output logic       mcr_rts_q
);

    fc_wsel_e sel;
    assign sel = fc_wsel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= fc_ctrl_t'(CTRL_RESET);
            mcr_rts_q <= 1'b0;
        end else if (wr_en) begin
            if (sel == WSEL_MODEM) begin
                mcr_rts_q <= wr_data[0];
            end else begin
                ctrl_q <= fc_ctrl_t'(wr_data);
            end
        end
    end

endmodule

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_fc_rts_gen.sv
module uart_fc_rts_gen
    import uart_fc_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  fc_ctrl_t         ctrl,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             mcr_rts,
    output logic             rts_pin
);

    logic [LVL_W-1:0] free_slots;
    logic [LVL_W-1:0] thr_ext;
    logic             room;

    always_comb begin
        if (rx_level >= LVL_W'(DEPTH)) free_slots = '0;
        else                           free_slots = LVL_W'(DEPTH) - rx_level;
        thr_ext = LVL_W'(thr_slots(ctrl.thr_sel));
        room    = (free_slots > thr_ext);
        if (ctrl.auto_rts) rts_pin = room ^ ctrl.rts_inv;
        else               rts_pin = mcr_rts;
    end

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_char_valid,
    input  logic             cts_pin,
    input  logic             tx_idle,
    output logic             rts_pin,
    output logic             rx_enable,
    output logic             rx_push,
    output logic             tx_permit
);

    fc_ctrl_t ctrl_q;
    logic     mcr_rts_q;
    logic     cts_sync;
    logic     cts_active;

    uart_fc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .mcr_rts_q(mcr_rts_q)
    );

    uart_fc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk(clk),
        .rst(rst),
        .d  (cts_pin),
        .q  (cts_sync)
    );

    uart_fc_rts_gen #(.DEPTH(FIFO_DEPTH)) u_rts (
        .ctrl    (ctrl_q),
        .rx_level(rx_level),
        .mcr_rts (mcr_rts_q),
        .rts_pin (rts_pin)
    );

    always_comb begin
        cts_active = cts_sync ^ ctrl_q.cts_inv;
        rx_enable  = ctrl_q.rx_en;
        rx_push    = rx_char_valid & ctrl_q.rx_en;
        tx_permit  = ctrl_q.tx_en & tx_idle & (~ctrl_q.auto_cts | cts_active);
    end

endmodule

// File: rtl/uart_flow_ctrl_checker.sv
module uart_flow_ctrl_checker
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [7:0]       wr_data,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_idle,
    input logic             rts_pin,
    input logic             rx_enable,
    input logic             rx_push,
    input logic             tx_permit,
    input fc_ctrl_t         ctrl_q
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_enable && ctrl_q == fc_ctrl_t'(CTRL_RESET)));

    assert_no_push_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> rx_enable);

    assert_tx_off_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !wr_data[1]) |=> !tx_permit);

    assert_full_releases_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.auto_rts && rx_level >= LVL_W'(FIFO_DEPTH)) |-> (rts_pin == ctrl_q.rts_inv));

    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_idle |-> !tx_permit);

    assert_manual_rts_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !ctrl_q.auto_rts) |=> (rts_pin == $past(wr_data[0])));

    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (rx_enable == $past(wr_data[0])));

endmodule

bind uart_flow_ctrl uart_flow_ctrl_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rx_level (rx_level),
    .tx_idle  (tx_idle),
    .rts_pin  (rts_pin),
    .rx_enable(rx_enable),
    .rx_push  (rx_push),
    .tx_permit(tx_permit),
    .ctrl_q   (ctrl_q)
);

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] rx_level = 4'd0;
    logic       rx_char_valid = 1'b0;
    logic       cts_pin = 1'b0;
    logic       tx_idle = 1'b1;
    logic       rts_pin, rx_enable, rx_push, tx_permit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state
    int m_ctrl = 3;
    int m_mcr  = 0;
    int m_s1   = 0;
    int m_s2   = 0;

    uart_flow_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_level(rx_level), .rx_char_valid(rx_char_valid), .cts_pin(cts_pin),
        .tx_idle(tx_idle), .rts_pin(rts_pin), .rx_enable(rx_enable),
        .rx_push(rx_push), .tx_permit(tx_permit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_thr(input int sel);
        if (sel == 0) return 3;
        if (sel == 1) return 2;
        if (sel == 2) return 1;
        return 4;
    endfunction

    function automatic int exp_rts();
        int free;
        int lvl;
        lvl  = rx_level;
        free = (lvl >= DEPTH) ? 0 : DEPTH - lvl;
        if ((m_ctrl & 4) == 0) return m_mcr;
        return ((free > exp_thr((m_ctrl >> 4) & 3)) ? 1 : 0) ^ ((m_ctrl >> 6) & 1);
    endfunction

    function automatic int exp_permit();
        int act;
        act = m_s2 ^ ((m_ctrl >> 7) & 1);
        if ((m_ctrl & 2) == 0 || !tx_idle) return 0;
        if ((m_ctrl & 8) != 0 && act == 0) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ctrl = 3; m_mcr = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (wr_en) begin
                if (wr_sel) m_mcr = wr_data[0];
                else        m_ctrl = wr_data;
            end
            m_s2 = m_s1;
            m_s1 = cts_pin;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(rx_enable == (m_ctrl & 1), "R2 rx_enable", rx_enable, m_ctrl & 1);
            chk(rx_push == ((m_ctrl & 1) & rx_char_valid), "R2 rx_push", rx_push,
                (m_ctrl & 1) & rx_char_valid);
            chk(tx_permit == exp_permit(), "R7 tx_permit", tx_permit, exp_permit());
            chk(rts_pin == exp_rts(), "R4 rts_pin", rts_pin, exp_rts());
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic wr(input bit s, input logic [7:0] d);
        wr_sel = s; wr_data = d; wr_en = 1'b1;
        cyc();
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        at_neg();
        // R1 reset state
        chk(rx_enable == 1'b1, "R1 rx_enable", rx_enable, 1);
        chk(rts_pin == 1'b0, "R1 rts_pin", rts_pin, 0);
        chk(tx_permit == 1'b1, "R1 tx_permit", tx_permit, 1);

        // R11: value driven but not yet clocked leaves outputs unchanged
        cyc();
        wr_sel = 0; wr_data = 8'h01; wr_en = 1'b1;
        at_neg();
        chk(tx_permit == 1'b1, "R11 before edge", tx_permit, 1);
        cyc();
        at_neg();
        chk(tx_permit == 1'b0, "R3 tx disabled", tx_permit, 0);
        chk(rx_enable == 1'b1, "R11 after edge", rx_enable, 1);

        // R2 receiver disabled discards characters
        wr(0, 8'h02);
        rx_char_valid = 1'b1;
        at_neg();
        chk(rx_push == 1'b0, "R2 discard", rx_push, 0);
        cyc();
        wr(0, 8'h03);
        at_neg();
        chk(rx_push == 1'b1, "R2 accept", rx_push, 1);
        rx_char_valid = 1'b0;

        // R4 / R5 threshold sweep
        for (int sel = 0; sel < 4; sel++) begin
            wr(0, 8'h07 | 8'(sel << 4));
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                rx_level = 4'(lvl);
                at_neg();
                chk(rts_pin == ((DEPTH - lvl) > exp_thr(sel)), "R5 threshold",
                    rts_pin, ((DEPTH - lvl) > exp_thr(sel)) ? 1 : 0);
                cyc();
            end
        end
        // R11: threshold change re-evaluated at a fixed level
        rx_level = 4'd4;
        wr(0, 8'h37);
        at_neg();
        chk(rts_pin == 1'b0, "R11 thr 4 at level 4", rts_pin, 0);
        wr(0, 8'h17);
        at_neg();
        chk(rts_pin == 1'b1, "R11 thr 2 at level 4", rts_pin, 1);

        // R6 inversion
        wr(0, 8'h57);
        at_neg();
        chk(rts_pin == 1'b0, "R6 inverted room", rts_pin, 0);
        rx_level = 4'd8;
        at_neg();
        chk(rts_pin == 1'b1, "R6 inverted full", rts_pin, 1);

        // R10 manual RTS, inversion ignored
        wr(0, 8'h43);
        wr(1, 8'h01);
        at_neg();
        chk(rts_pin == 1'b1, "R10 manual high", rts_pin, 1);
        wr(1, 8'h00);
        at_neg();
        chk(rts_pin == 1'b0, "R10 manual low", rts_pin, 0);
        rx_level = 4'd0;

        // R7 / R9 automatic CTS with latency
        cts_pin = 1'b0;
        wr(0, 8'h0B);
        cyc();
        at_neg();
        chk(tx_permit == 1'b0, "R7 cts inactive", tx_permit, 0);
        cyc();
        cts_pin = 1'b1;
        at_neg();
        cyc();
        at_neg();
        chk(tx_permit == 1'b0, "R9 one edge", tx_permit, 0);
        cyc();
        at_neg();
        chk(tx_permit == 1'b1, "R9 two edges", tx_permit, 1);
        tx_idle = 1'b0;
        at_neg();
        chk(tx_permit == 1'b0, "R7 busy shifter", tx_permit, 0);
        tx_idle = 1'b1;

        // R8 CTS polarity inversion
        wr(0, 8'h8B);
        at_neg();
        chk(tx_permit == 1'b0, "R8 inverted high", tx_permit, 0);
        cts_pin = 1'b0;
        cyc(); cyc();
        at_neg();
        chk(tx_permit == 1'b1, "R8 inverted low", tx_permit, 1);

        repeat (3) cyc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule